// File: doc/BRIEF.md
# Vector Narrowing Pack Unit

This block takes two 128-bit source vectors and turns them into one 128-bit result. Every result element is half as wide as a source element, so the narrowed elements of the first vector fill the upper half of the result and those of the second vector fill the lower half. The narrowing is done in one of three ways. Truncation keeps the low half of each element. Signed saturation clamps each element to the narrow two's-complement range. Unsigned saturation clamps each element to the narrow unsigned maximum.

An operation is issued with a one-cycle strobe. The result appears exactly one cycle later, with a result-valid pulse. In the two saturating modes the caller can also ask for a 2-bit condition code that tells whether no element, some elements or every element was clamped. A source element size that the unit does not support raises a specification-error pulse instead of producing a result.

Top module: `vec_narrow_pack`

## Requirements
- R1: Elements are numbered from the most significant end, so element 0 occupies the top bits. With N source elements per vector, result element i comes from element i of `src_a` when i < N, and from element i−N of `src_b` otherwise.
- R2: With `mode` = 0 (truncate), or the unused code 3, each result element is the low half of its source element.
- R3: With `mode` = 1 (signed saturate), each source element is read as two's complement. A value above the narrow signed maximum becomes that maximum, a value below the narrow signed minimum becomes that minimum, and any other value is kept.
- R4: With `mode` = 2 (unsigned saturate), each source element is read as unsigned. A value above the narrow unsigned maximum (all ones) becomes all ones. There is no lower clamp, so a source whose top bit is set also clamps to all ones.
- R5: `elem_size` codes 1, 2 and 3 select source elements of 16, 32 and 64 bits. Code 0 and codes 4 to 7 are illegal. An illegal code pulses `spec_err` one cycle after issue, keeps `res_valid` and `cc_valid` low, and leaves `result` and `cc` unchanged.
- R6: `cc` is updated, and `cc_valid` pulses together with `res_valid`, only when `cc_en` is set and `mode` is 1 or 2. In every other case `cc` keeps its previous value.
- R7: The condition code is 0 when no result element saturated, 1 when some but not all did, and 3 when every result element saturated. The code 2 never appears.
- R8: `result`, `res_valid`, `cc` and `cc_valid` are registered one cycle after the `op_valid` cycle. In a cycle after `op_valid` was low, all three pulse outputs are low and `result` holds its value.
- R9: After a synchronous active-low reset, `result` and `cc` are zero and `res_valid`, `cc_valid` and `spec_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Issue strobe; the operands are sampled on this cycle's rising edge |
| src_a | input | 128 | First source vector (upper half of the result) |
| src_b | input | 128 | Second source vector (lower half of the result) |
| elem_size | input | 3 | Source element size code: 1 = 16, 2 = 32, 3 = 64 bits; other codes are illegal |
| mode | input | 2 | 0 truncate, 1 signed saturate, 2 unsigned saturate, 3 treated as truncate |
| cc_en | input | 1 | Request a condition-code update (saturating modes only) |
| result | output | 128 | Packed narrow vector |
| res_valid | output | 1 | One-cycle pulse: `result` was updated |
| cc | output | 2 | Condition code: 0 none, 1 some, 3 all elements saturated |
| cc_valid | output | 1 | One-cycle pulse: `cc` was updated |
| spec_err | output | 1 | One-cycle pulse: illegal element size was issued |

## Verification
Ascending byte patterns in truncate mode, checked against hand-written literals, expose any swap in element order or mixing up of the two halves. Signed tests place values just inside and just outside the narrow range, in both directions. They separate a correct clamp from an off-by-one bound and from a wrong sign choice. The same tests also drive the condition code through none, some and every element saturated. Unsigned tests use values with the top bit set, which tells a missing lower-clamp exemption apart from a signed reading. Pseudo-random operands cover all sizes and modes, and illegal size codes, cleared enables and idle cycles show that `result` and `cc` hold their values.

// File: rtl/vnp_pkg.sv
// Package: shared types and helpers for the vector narrowing pack unit.
// Assumes a fixed mapping of mode codes; code 3 is unused and behaves as truncate.
package vnp_pkg;

    typedef enum logic [1:0] {
        PK_TRUNC = 2'd0,
        PK_SSAT  = 2'd1,
        PK_USAT  = 2'd2,
        PK_RSVD  = 2'd3
    } pack_mode_e;

    localparam int SIZE_CODE_W = 3;
    localparam int MIN_SIZE_CODE = 1;   // 16-bit source elements
    localparam int MAX_SIZE_CODE = 3;   // 64-bit source elements

    // Encode the saturation summary into the 2-bit condition code.
    function automatic logic [1:0] cc_encode(input logic any_sat, input logic all_sat);
        if (all_sat)      return 2'd3;
        else if (any_sat) return 2'd1;
        else              return 2'd0;
    endfunction

    // True when the mode clamps elements, so a condition code is meaningful.
    function automatic logic is_saturating(input pack_mode_e m);
        return (m == PK_SSAT) || (m == PK_USAT);
    endfunction

endpackage

// File: rtl/vnp_lane.sv
// Module: narrows one source element to half its width.
// Assumes SRC_W is even. Purely combinational; sat flags a clamped value.
module vnp_lane
    import vnp_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   src,
    input  pack_mode_e         mode,
    output logic [SRC_W/2-1:0] dst,
    output logic               sat
);
    localparam int DST_W = SRC_W / 2;

    logic [SRC_W-DST_W-1:0] upper;
    logic [SRC_W-DST_W:0]   sign_run;
    logic                   fits_signed;
    logic                   fits_unsigned;

    // Range tests: signed fits when the dropped bits copy the new sign bit.
    always_comb begin
        upper         = src[SRC_W-1:DST_W];
        sign_run      = src[SRC_W-1:DST_W-1];
        fits_signed   = (&sign_run) | ~(|sign_run);
        fits_unsigned = ~(|upper);
    end

    // Per-mode narrowing with clamping.
    always_comb begin
        dst = src[DST_W-1:0];
        sat = 1'b0;
        unique case (mode)
            PK_SSAT: begin
                if (!fits_signed) begin
                    sat = 1'b1;
                    dst = src[SRC_W-1] ? {1'b1, {(DST_W-1){1'b0}}}
                                       : {1'b0, {(DST_W-1){1'b1}}};
                end
            end
            PK_USAT: begin
                if (!fits_unsigned) begin
                    sat = 1'b1;
                    dst = {DST_W{1'b1}};
                end
            end
            default: begin
                dst = src[DST_W-1:0];
                sat = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vnp_width_path.sv
// Module: packs two vectors for one fixed source element width.
// Assumes VEC_W is a multiple of SRC_W. Element 0 is the most significant.
// Reports whether any and whether all of the result elements saturated.
module vnp_width_path
    import vnp_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SRC_W = 16
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  pack_mode_e       mode,
    output logic [VEC_W-1:0] packed_vec,
    output logic             any_sat,
    output logic             all_sat
);
    localparam int DST_W   = SRC_W / 2;
    localparam int N_SRC   = VEC_W / SRC_W;
    localparam int N_DST   = 2 * N_SRC;

    logic [N_DST-1:0] sat_vec;

    for (genvar e = 0; e < N_DST; e++) begin : g_elem
        logic [SRC_W-1:0] src_elem;
        logic [DST_W-1:0] dst_elem;

        if (e < N_SRC) begin : g_from_a
            assign src_elem = vec_a[VEC_W-1-e*SRC_W -: SRC_W];
        end else begin : g_from_b
            assign src_elem = vec_b[VEC_W-1-(e-N_SRC)*SRC_W -: SRC_W];
        end

        vnp_lane #(.SRC_W(SRC_W)) u_lane (
            .src  (src_elem),
            .mode (mode),
            .dst  (dst_elem),
            .sat  (sat_vec[e])
        );

        assign packed_vec[VEC_W-1-e*DST_W -: DST_W] = dst_elem;
    end

    // Saturation summary across all result elements.
    always_comb begin
        any_sat = |sat_vec;
        all_sat = &sat_vec;
    end

endmodule

// File: rtl/vec_narrow_pack.sv
// Module: top of the vector narrowing pack unit.
// Runs one packing path per legal element size in parallel, selects one with
// elem_size and registers the result one cycle after op_valid. Assumes the
// caller gives the operands on the op_valid cycle; there is no back-pressure.
module vec_narrow_pack
    import vnp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [VEC_W-1:0]       src_a,
    input  logic [VEC_W-1:0]       src_b,
    input  logic [SIZE_CODE_W-1:0] elem_size,
    input  logic [1:0]             mode,
    input  logic                   cc_en,
    output logic [VEC_W-1:0]       result,
    output logic                   res_valid,
    output logic [1:0]             cc,
    output logic                   cc_valid,
    output logic                   spec_err
);
    localparam int N_PATHS = MAX_SIZE_CODE - MIN_SIZE_CODE + 1;

    pack_mode_e       mode_e;
    logic [VEC_W-1:0] path_vec [N_PATHS];
    logic             path_any [N_PATHS];
    logic             path_all [N_PATHS];
    logic [VEC_W-1:0] sel_vec;
    logic [1:0]       sel_cc;
    logic             size_ok;
    logic             cc_req;

    assign mode_e = pack_mode_e'(mode);

    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        vnp_width_path #(
            .VEC_W (VEC_W),
            .SRC_W (8 << (p + MIN_SIZE_CODE))
        ) u_path (
            .vec_a      (src_a),
            .vec_b      (src_b),
            .mode       (mode_e),
            .packed_vec (path_vec[p]),
            .any_sat    (path_any[p]),
            .all_sat    (path_all[p])
        );
    end

    // Decode size legality and pick the matching path output.
    always_comb begin
        size_ok = (int'(elem_size) >= MIN_SIZE_CODE) && (int'(elem_size) <= MAX_SIZE_CODE);
        sel_vec = '0;
        sel_cc  = 2'd0;
        for (int p = 0; p < N_PATHS; p++) begin
            if (int'(elem_size) == p + MIN_SIZE_CODE) begin
                sel_vec = path_vec[p];
                sel_cc  = cc_encode(path_any[p], path_all[p]);
            end
        end
        cc_req = cc_en && is_saturating(mode_e);
    end

    // Output register: result, condition code and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
            cc        <= 2'd0;
            cc_valid  <= 1'b0;
            spec_err  <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            cc_valid  <= 1'b0;
            spec_err  <= 1'b0;
            if (op_valid) begin
                if (!size_ok) begin
                    spec_err <= 1'b1;
                end else begin
                    result    <= sel_vec;
                    res_valid <= 1'b1;
                    if (cc_req) begin
                        cc       <= sel_cc;
                        cc_valid <= 1'b1;
                    end
                end
            end
        end
    end

    // An error pulse excludes any result or condition-code pulse (R5).
    p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> (!res_valid && !cc_valid));

    // An illegal issue leaves result and cc untouched (R5).
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> ($stable(result) && $stable(cc)));

    // cc only moves on a cc_valid pulse (R6).
    p_cc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_valid |-> $stable(cc));

    // A cc update always comes with a result (R6).
    p_cc_with_res_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> res_valid);

    // Code 2 is never produced (R7).
    p_cc_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> (cc != 2'd2));

    // Any pulse is the answer to an issue one cycle earlier (R8).
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || spec_err) |-> $past(op_valid));

    // Without a result pulse the result register holds (R8).
    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(result));

    // At most one of result and error pulses at a time (R5).
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, spec_err}));

endmodule

// File: tb/sim_vec_narrow_pack.sv
module sim_vec_narrow_pack;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [127:0] src_a, src_b;
    logic [2:0]   elem_size;
    logic [1:0]   mode;
    logic         cc_en;
    logic [127:0] result;
    logic         res_valid;
    logic [1:0]   cc;
    logic         cc_valid;
    logic         spec_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [127:0] exp_res;
    logic [1:0]   exp_cc;
    logic [63:0]  seed = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;   // 125 MHz

    vec_narrow_pack u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .src_a(src_a), .src_b(src_b), .elem_size(elem_size),
        .mode(mode), .cc_en(cc_en), .result(result),
        .res_valid(res_valid), .cc(cc), .cc_valid(cc_valid),
        .spec_err(spec_err)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent model of the packing rules.
    function automatic void ref_pack(input logic [127:0] a, input logic [127:0] b,
                                     input int sz, input int md,
                                     output logic [127:0] r, output logic [1:0] c);
        int sw, dw, n, cnt, k;
        logic [127:0] sv;
        logic [63:0] e, o, smask, dmask;
        longint se, mx, mn;
        sw = 8 << sz; dw = sw / 2; n = 128 / sw; cnt = 0; r = '0;
        smask = (sw == 64) ? '1 : ((64'd1 << sw) - 64'd1);
        dmask = (64'd1 << dw) - 64'd1;
        for (int i = 0; i < 2 * n; i++) begin
            sv = (i < n) ? a : b;
            k  = (i < n) ? i : i - n;
            e  = 64'(sv >> (128 - (k + 1) * sw)) & smask;
            se = longint'(e << (64 - sw)) >>> (64 - sw);
            o  = e;
            if (md == 1) begin
                mx = (longint'(1) <<< (dw - 1)) - 1;
                mn = -mx - 1;
                if (se > mx) begin o = 64'(mx); cnt++; end
                else if (se < mn) begin o = 64'(mn); cnt++; end
            end else if (md == 2) begin
                if (e > dmask) begin o = dmask; cnt++; end
            end
            o = o & dmask;
            r = r | ({64'd0, o} << (128 - (i + 1) * dw));
        end
        c = (cnt == 2 * n) ? 2'd3 : (cnt > 0) ? 2'd1 : 2'd0;
    endfunction

    // Issue one operation and wait until its outputs are registered.
    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input logic [2:0] sz, input logic [1:0] md, input logic ce);
        @(negedge clk);
        src_a = a; src_b = b; elem_size = sz; mode = md; cc_en = ce; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Issue a legal operation and check it against the model.
    task automatic run_legal(input string req, input logic [127:0] a, input logic [127:0] b,
                             input logic [2:0] sz, input logic [1:0] md, input logic ce);
        logic [127:0] r; logic [1:0] c; logic upd;
        ref_pack(a, b, int'(sz), (md == 2'd3) ? 0 : int'(md), r, c);
        upd = ce && (md == 2'd1 || md == 2'd2);
        issue(a, b, sz, md, ce);
        exp_res = r;
        if (upd) exp_cc = c;
        chk({req, " result"}, result, exp_res);
        chk({req, " res_valid (R8)"}, 128'(res_valid), 128'd1);
        chk({req, " cc_valid (R6)"}, 128'(cc_valid), 128'(upd));
        chk({req, " cc (R6/R7)"}, 128'(cc), 128'(exp_cc));
    endtask

    task automatic t_reset;
        chk("R9 result", result, '0);
        chk("R9 cc", 128'(cc), '0);
        chk("R9 pulses", 128'({res_valid, cc_valid, spec_err}), '0);
    endtask

    task automatic t_order_trunc;
        issue(128'h0123456789ABCDEF_FEDCBA9876543210,
              128'h0011223344556677_8899AABBCCDDEEFF, 3'd3, 2'd0, 1'b1);
        exp_res = 128'h89ABCDEF_76543210_44556677_CCDDEEFF;
        chk("R1 order 64->32", result, exp_res);
        chk("R6 no cc in truncate", 128'(cc_valid), '0);
        issue(128'h000102030405060708090A0B0C0D0E0F,
              128'h101112131415161718191A1B1C1D1E1F, 3'd1, 2'd0, 1'b0);
        exp_res = 128'h01030507090B0D0F_11131517191B1D1F;
        chk("R2 truncate 16->8", result, exp_res);
        run_legal("R2 truncate 32->16", 128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0,
                  128'h0BADC0DE_FACEFEED_00000001_FFFFFFFF, 3'd2, 2'd0, 1'b0);
        run_legal("R2 mode3 as truncate", 128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0,
                  128'h0BADC0DE_FACEFEED_00000001_FFFFFFFF, 3'd2, 2'd3, 1'b1);
    endtask

    task automatic t_signed;
        issue({8{16'h0100}}, {8{16'hFE00}}, 3'd1, 2'd1, 1'b1);
        exp_res = {{8{8'h7F}}, {8{8'h80}}}; exp_cc = 2'd3;
        chk("R3 clamp max/min", result, exp_res);
        chk("R7 all saturated cc=3", 128'(cc), 128'(exp_cc));
        // boundaries: 127,128,-128,-129 -> 7F,7F,80,80; two of 16 saturate
        run_legal("R3 bounds 16->8", {16'h007F, 16'h0080, 16'hFF80, 16'hFF7F, 64'h0},
                  128'h0, 3'd1, 2'd1, 1'b1);
        chk("R7 some saturated cc=1", 128'(cc), 128'd1);
        run_legal("R3 none 32->16", {32'h00007FFF, 32'hFFFF8000, 32'h00000000, 32'hFFFFFFFF},
                  {32'h00001234, 32'hFFFFEDCC, 32'h00000001, 32'h00007FFE}, 3'd2, 2'd1, 1'b1);
        chk("R7 none saturated cc=0", 128'(cc), 128'd0);
        run_legal("R3 64->32", {64'h0000000080000000, 64'hFFFFFFFF7FFFFFFF},
                  {64'h000000007FFFFFFF, 64'hFFFFFFFF80000000}, 3'd3, 2'd1, 1'b1);
    endtask

    task automatic t_unsigned;
        run_legal("R4 16->8", {16'h00FF, 16'h0100, 16'h8000, 16'hFFFF, 16'h0000, 16'h0001, 16'h00FE, 16'h7FFF},
                  128'h0, 3'd1, 2'd2, 1'b1);
        chk("R4 top-bit element clamps high", result[111:104], 128'hFF);
        run_legal("R4 64->32 all", {2{64'h8000000000000000}}, {2{64'h0000000100000000}},
                  3'd3, 2'd2, 1'b1);
        chk("R7 unsigned all cc=3", 128'(cc), 128'd3);
    endtask

    task automatic t_cc_disable;
        // saturating, but cc_en low: cc must keep its value (R6)
        run_legal("R6 cc_en off", {8{16'h0100}}, {8{16'h0100}}, 3'd1, 2'd1, 1'b0);
        chk("R6 cc held", 128'(cc), 128'd3);
    endtask

    task automatic t_illegal;
        logic [2:0] codes [3] = '{3'd0, 3'd4, 3'd7};
        for (int i = 0; i < 3; i++) begin
            issue(~128'h0, 128'h5A5A, codes[i], 2'd1, 1'b1);
            chk("R5 spec_err", 128'(spec_err), 128'd1);
            chk("R5 no res_valid/cc_valid", 128'({res_valid, cc_valid}), '0);
            chk("R5 result held", result, exp_res);
            chk("R5 cc held", 128'(cc), 128'(exp_cc));
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        src_a = ~128'h0; src_b = ~128'h0; elem_size = 3'd1; mode = 2'd1; cc_en = 1'b1;
        @(negedge clk);
        chk("R8 idle pulses low", 128'({res_valid, cc_valid, spec_err}), '0);
        chk("R8 idle result held", result, exp_res);
    endtask

    function automatic logic [63:0] nxt(input logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13; x ^= x >> 7; x ^= x << 17;
        return x;
    endfunction

    task automatic t_random;
        logic [127:0] a, b;
        for (int i = 0; i < 36; i++) begin
            seed = nxt(seed); a[127:64] = seed;
            seed = nxt(seed); a[63:0]   = seed;
            seed = nxt(seed); b[127:64] = seed;
            seed = nxt(seed); b[63:0]   = seed;
            if (i % 4 == 1) a = a >> (seed[5:0] + 60);
            run_legal("R1 random", a, b, 3'(1 + i % 3), 2'((i / 3) % 3), seed[0]);
        end
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; src_a = '0; src_b = '0;
        elem_size = 3'd1; mode = 2'd0; cc_en = 1'b0;
        exp_res = '0; exp_cc = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_order_trunc;
        t_signed;
        t_unsigned;
        t_cc_disable;
        t_illegal;
        t_idle;
        t_random;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule